// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store command into a stream of per-element memory requests. A command names an addressing mode, a scalar base address, a signed byte stride, the element width and the active element count. Once accepted, the generator emits one request per accepted handshake. Each request carries a byte address, the element size in bytes, the element index and the transfer direction. After the last element it raises a one-cycle completion pulse.

There are three addressing modes. In unit-stride mode the elements are packed back to back, so the address grows by the element size. In strided mode the address grows by a signed byte distance, which may be zero or negative. In indexed mode each address is the base plus a byte offset taken from a streaming input, with one offset consumed per issued element. The sequencer moves through three named states. IDLE waits for a command. ISSUE emits elements. FINISH holds the completion pulse for one cycle. The transitions are: IDLE to ISSUE on an accepted start with a non-zero count; IDLE to FINISH on an accepted start with a zero count; ISSUE to ISSUE while elements remain; ISSUE to FINISH when the last element is accepted; FINISH to IDLE unconditionally.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, req_valid_o and off_ready_o are all low.
- R2: With mode_i = 0 (unit-stride), element i has address base + i*size. Mode value 3 behaves as unit-stride.
- R3: With mode_i = 1 (strided), element i has address base + i*stride, where stride is two's complement. Arithmetic wraps modulo 2^XLEN, and a zero stride repeats the base for every element.
- R4: With mode_i = 2 (indexed), element i has address base + offset_i. req_valid_o is low while off_valid_i is low. An offset is consumed (off_valid_i and off_ready_o both high) only in a cycle where a request is accepted, so exactly vl offsets are consumed. off_ready_o is never high in the other modes.
- R5: sew_i selects the element size: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. req_size_o carries that byte count as a binary value, so exactly one bit of it is set.
- R6: Exactly vl requests are issued, with req_idx_o running 0 to vl-1 in order. While req_valid_o is high and req_ready_i is low, the index and size are held, and no element is skipped or repeated.
- R7: When vl_i = 0, no request is issued, and done_o is high in the cycle right after the accepting clock edge.
- R8: done_o is high for exactly one cycle, the cycle after the last request is accepted. busy_o is high from acceptance through that cycle. start_i and the command inputs are ignored while busy_o is high.
- R9: req_store_o equals is_store_i as captured at acceptance, and stays constant through the whole command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe; accepted only when idle |
| mode_i | input | 2 | 0 unit-stride, 1 strided, 2 indexed, 3 as unit-stride |
| is_store_i | input | 1 | Direction of the command: 1 store, 0 load |
| base_i | input | XLEN | Scalar base byte address |
| stride_i | input | XLEN | Signed byte stride for strided mode |
| sew_i | input | 2 | Element width code (size = 2^sew_i bytes) |
| vl_i | input | VL_W | Number of active elements |
| off_valid_i | input | 1 | Offset stream valid |
| off_data_i | input | XLEN | Byte offset for the next indexed element |
| off_ready_o | output | 1 | Offset stream ready |
| req_valid_o | output | 1 | Element request valid |
| req_ready_i | input | 1 | Memory side accepts the request |
| req_addr_o | output | XLEN | Element byte address |
| req_size_o | output | 4 | Element size in bytes |
| req_idx_o | output | VL_W | Element index |
| req_store_o | output | 1 | Direction of the request |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
In indexed mode, memory backpressure and starvation of the offset stream can land in the same cycle. The stream handshake must then neither consume an offset nor advance the element. The bench provokes this by driving req_ready_i and off_valid_i independently from random draws at a range of probabilities. It judges the result by checking every accepted address against base plus the offset at the bench's own consumption count, and by checking that the number of offsets consumed equals vl. A second overlap is a new start_i pulse with a changed command while the last element is accepted or while done_o is high. Random start pulses and scrambled command inputs during every run must leave the addresses and the element count unchanged.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT   = 2'd0,
        MODE_STRIDE = 2'd1,
        MODE_INDEX  = 2'd2,
        MODE_RSVD   = 2'd3
    } vag_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } vag_state_e;

    typedef struct packed {
        vag_mode_e  mode;
        logic       store;
        logic [1:0] sew;
    } vag_cfg_t;

endpackage

// File: rtl/vag_width_dec.sv
module vag_width_dec #(
    parameter int CODE_W = 2,
    localparam int SIZE_W = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] sew_i,
    output logic [SIZE_W-1:0] size_o
);

    // Size in bytes is 2^sew, which is one-hot in binary.
    for (genvar g = 0; g < SIZE_W; g++) begin : g_bit
        assign size_o[g] = (sew_i == CODE_W'(g));
    end

endmodule

// File: rtl/vag_fsm.sv
module vag_fsm
    import vag_pkg::*;
#(
    parameter int VL_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic            fire_i,
    output vag_state_e      state_o,
    output logic [VL_W-1:0] idx_o
);

    vag_state_e      state_q, state_d;
    logic [VL_W-1:0] idx_q;
    logic [VL_W-1:0] vl_q;
    logic            last_elem;

    assign last_elem = (idx_q == vl_q - VL_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_i) begin
                    state_d = (vl_i == '0) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (fire_i && last_elem) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            vl_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept_i) begin
                idx_q <= '0;
                vl_q  <= vl_i;
            end else if (fire_i) begin
                idx_q <= idx_q + VL_W'(1);
            end
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/vag_addr_path.sv
module vag_addr_path
    import vag_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   stride_i,
    input  vag_mode_e         mode_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              fire_i,
    input  logic [XLEN-1:0]   off_data_i,
    output logic [XLEN-1:0]   addr_o
);

    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] stride_q;
    logic [XLEN-1:0] run_q;
    logic [XLEN-1:0] step;

    // Step added after each accepted element; wraps modulo 2^XLEN.
    always_comb begin
        unique case (mode_i)
            MODE_STRIDE: step = stride_q;
            default:     step = XLEN'(size_i);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            run_q    <= '0;
        end else if (load_i) begin
            base_q   <= base_i;
            stride_q <= stride_i;
            run_q    <= base_i;
        end else if (fire_i) begin
            run_q    <= run_q + step;
        end
    end

    always_comb begin
        unique case (mode_i)
            MODE_INDEX: addr_o = base_q + off_data_i;
            default:    addr_o = run_q;
        endcase
    end

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VL_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      mode_i,
    input  logic            is_store_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] stride_i,
    input  logic [1:0]      sew_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic            off_valid_i,
    input  logic [XLEN-1:0] off_data_i,
    output logic            off_ready_o,
    output logic            req_valid_o,
    input  logic            req_ready_i,
    output logic [XLEN-1:0] req_addr_o,
    output logic [3:0]      req_size_o,
    output logic [VL_W-1:0] req_idx_o,
    output logic            req_store_o,
    output logic            busy_o,
    output logic            done_o
);

    localparam int SIZE_W = 4;

    vag_state_e      state;
    vag_cfg_t        cfg_q;
    logic            accept;
    logic            fire;
    logic            indexed;
    logic [SIZE_W-1:0] size;
    logic [VL_W-1:0] idx;

    assign accept  = start_i && (state == ST_IDLE);
    assign indexed = (cfg_q.mode == MODE_INDEX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_UNIT, store: 1'b0, sew: 2'd0};
        end else if (accept) begin
            cfg_q <= '{mode: vag_mode_e'(mode_i), store: is_store_i, sew: sew_i};
        end
    end

    vag_fsm #(.VL_W(VL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .vl_i     (vl_i),
        .fire_i   (fire),
        .state_o  (state),
        .idx_o    (idx)
    );

    vag_width_dec #(.CODE_W(2)) u_wdec (
        .sew_i  (cfg_q.sew),
        .size_o (size)
    );

    vag_addr_path #(.XLEN(XLEN), .SIZE_W(SIZE_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .base_i     (base_i),
        .stride_i   (stride_i),
        .mode_i     (cfg_q.mode),
        .size_i     (size),
        .fire_i     (fire),
        .off_data_i (off_data_i),
        .addr_o     (req_addr_o)
    );

    // Output process: decoded from the state register and the stream inputs.
    always_comb begin
        req_valid_o = 1'b0;
        off_ready_o = 1'b0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state)
            ST_IDLE:   busy_o = 1'b0;
            ST_ISSUE: begin
                req_valid_o = indexed ? off_valid_i : 1'b1;
                off_ready_o = indexed && req_ready_i;
            end
            ST_FINISH: done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    assign fire        = req_valid_o && req_ready_i;
    assign req_size_o  = size;
    assign req_idx_o   = idx;
    assign req_store_o = cfg_q.store;

endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
    parameter int XLEN = 64,
    parameter int VL_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            off_valid_i,
    input logic            off_ready_o,
    input logic            req_valid_o,
    input logic            req_ready_i,
    input logic [3:0]      req_size_o,
    input logic [VL_W-1:0] req_idx_o,
    input logic            req_store_o,
    input logic            busy_o,
    input logic            done_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!req_valid_o && !off_ready_o && !done_o));

    assert_offset_with_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (off_valid_i && off_ready_o) |-> (req_valid_o && req_ready_i));

    assert_size_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ($countones(req_size_o) == 1));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> ($stable(req_idx_o) && $stable(req_size_o) && busy_o));

    assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> (done_o || (req_idx_o == $past(req_idx_o) + VL_W'(1))));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !req_valid_o));

    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(req_store_o));

endmodule

bind vec_addr_gen vag_checker #(.XLEN(XLEN), .VL_W(VL_W)) u_vag_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .off_valid_i (off_valid_i),
    .off_ready_o (off_ready_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_size_o  (req_size_o),
    .req_idx_o   (req_idx_o),
    .req_store_o (req_store_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/test_vec_addr_gen.sv
`timescale 1ns/1ps
module test_vec_addr_gen;

    localparam int XLEN = 64;
    localparam int VL_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [1:0]      mode_i = '0;
    logic            is_store_i = 1'b0;
    logic [XLEN-1:0] base_i = '0;
    logic [XLEN-1:0] stride_i = '0;
    logic [1:0]      sew_i = '0;
    logic [VL_W-1:0] vl_i = '0;
    logic            off_valid_i = 1'b0;
    logic [XLEN-1:0] off_data_i = '0;
    logic            off_ready_o;
    logic            req_valid_o;
    logic            req_ready_i = 1'b0;
    logic [XLEN-1:0] req_addr_o;
    logic [3:0]      req_size_o;
    logic [VL_W-1:0] req_idx_o;
    logic            req_store_o;
    logic            busy_o;
    logic            done_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [63:0] offs [64];

    always #5 clk = ~clk;

    vec_addr_gen #(.XLEN(XLEN), .VL_W(VL_W)) i_vec_addr_gen (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    function automatic logic [63:0] exp_addr(input logic [1:0] m, input logic [63:0] b,
                                             input logic [63:0] s, input logic [1:0] w, input int i);
        logic [63:0] ii = 64'(i);
        case (m)
            2'd1:    return b + ii * s;
            2'd2:    return b + offs[i];
            default: return b + ii * (64'd1 << w);
        endcase
    endfunction

    // Entered and left at one time unit after a rising edge.
    task automatic run_op(input logic [1:0] m, input logic [63:0] b, input logic [63:0] s,
                          input logic [1:0] w, input int vl, input bit st,
                          input int rdy_pct, input int ov_pct);
        int n = 0;
        int k = 0;
        int last_c = -1;
        int c = 0;
        bit finished = 0;
        for (int i = 0; i < 64; i++) offs[i] = {$urandom, $urandom};
        start_i = 1'b1; mode_i = m; base_i = b; stride_i = s;
        sew_i = w; vl_i = VL_W'(vl); is_store_i = st;
        @(posedge clk); #1;
        while (!finished) begin
            // Scrambled command and stray starts must be ignored (R8).
            start_i    = ($urandom % 4) == 0;
            mode_i     = 2'($urandom);
            base_i     = {$urandom, $urandom};
            stride_i   = {$urandom, $urandom};
            sew_i      = 2'($urandom);
            vl_i       = VL_W'($urandom);
            is_store_i = 1'($urandom);
            req_ready_i = int'($urandom % 100) < rdy_pct;
            off_valid_i = int'($urandom % 100) < ov_pct;
            off_data_i  = offs[k];
            #3;
            if (c == 0) chk(busy_o == 1'b1, "R8 busy after accept", 64'(busy_o), 64'd1);
            if (done_o) begin
                chk(c == last_c + 1, "R8 done timing (R7 when vl=0)", 64'(c), 64'(last_c + 1));
                chk(!req_valid_o, "R7 no request with done", 64'(req_valid_o), 64'd0);
                finished = 1;
                start_i = 1'b0;
            end else begin
                if (m == 2'd2 && !off_valid_i)
                    chk(!req_valid_o, "R4 stall on empty offset stream", 64'(req_valid_o), 64'd0);
                if (m != 2'd2)
                    chk(!off_ready_o, "R4 no offset ready outside indexed", 64'(off_ready_o), 64'd0);
                if (req_valid_o && req_ready_i) begin
                    chk(n < vl, "R6 request beyond vl", 64'(n), 64'(vl));
                    chk(req_addr_o == exp_addr(m, b, s, w, n),
                        (m == 2'd1) ? "R3 strided address" : (m == 2'd2) ? "R4 indexed address" : "R2 unit address",
                        req_addr_o, exp_addr(m, b, s, w, n));
                    chk(req_idx_o == VL_W'(n), "R6 element index", 64'(req_idx_o), 64'(n));
                    chk(req_size_o == (4'd1 << w), "R5 element size", 64'(req_size_o), 64'(4'd1 << w));
                    chk(req_store_o == st, "R9 direction", 64'(req_store_o), 64'(st));
                    n++;
                    last_c = c;
                end
                if (off_valid_i && off_ready_o) k++;
            end
            @(posedge clk); #1;
            c++;
            if (c > 3000) begin
                chk(0, "R6 operation hung", 64'(c), 64'd3000);
                finished = 1;
            end
        end
        chk(n == vl, "R6 request count", 64'(n), 64'(vl));
        if (m == 2'd2) chk(k == vl, "R4 offsets consumed", 64'(k), 64'(vl));
        chk(!busy_o && !done_o, "R8 idle after done", 64'({busy_o, done_o}), 64'd0);
        req_ready_i = 1'b0;
        off_valid_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        chk(!busy_o && !done_o && !req_valid_o && !off_ready_o, "R1 reset state",
            64'({busy_o, done_o, req_valid_o, off_ready_o}), 64'd0);
        @(posedge clk); #1;
        // Directed corner cases
        run_op(2'd0, 64'h1000, 64'd0, 2'd2, 0, 1'b0, 100, 100);                // R7 unit
        run_op(2'd2, 64'h2000, 64'd0, 2'd0, 0, 1'b1, 100, 100);                // R7 indexed
        run_op(2'd0, 64'h4000, 64'd0, 2'd3, 1, 1'b1, 100, 100);                // vl = 1
        run_op(2'd1, 64'h8000, 64'd0, 2'd1, 6, 1'b0, 100, 100);                // R3 zero stride
        run_op(2'd1, 64'h10, -64'sd24, 2'd3, 5, 1'b1, 60, 100);                // R3 negative, wraps
        run_op(2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 2'd3, 5, 1'b0, 100, 100); // R2 wrap
        run_op(2'd3, 64'h300, 64'd0, 2'd1, 7, 1'b0, 50, 100);                  // R2 reserved mode
        run_op(2'd2, 64'h5000, 64'd0, 2'd2, 10, 1'b0, 30, 30);                 // R4 joint stalls
        // Constrained random commands
        for (int t = 0; t < 60; t++) begin
            run_op(2'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom),
                   int'($urandom % 25), 1'($urandom), 20 + int'($urandom % 81), 20 + int'($urandom % 81));
        end
        summary();
        $finish;
    end

endmodule